// File: doc/BRIEF.md
# Receive Line Status with Per-Entry Error Tags

This block holds the receive-side status path of a 16550-class serial port. A receiver front end hands over each deserialized character with three flags: bad parity, bad stop bit and break. The block stores the character and its flags together in a receive FIFO. The host pops characters through a receive-buffer read strobe. It samples an 8-bit line status word through a separate status-read strobe, and that read clears the sticky flags.

Because each stored character carries its own flags, the parity, framing and break bits always describe the character at the head of the FIFO. An aggregate error bit reports whether any error-tagged character is still queued. The transmit side supplies its holding-FIFO empty, shift-register empty and idle levels. The block turns these into the two transmit status bits, and holds both bits low while a break is being sent.

Top module: `rx_line_status`

## Requirements
- R1: Status bit 0 is 1 exactly when the receive FIFO holds at least one character. `rbr_data_o` shows the data byte of the head entry, or 0x00 when the FIFO is empty.
- R2: A character accepted on `rx_valid_i` is stored with its parity and framing flags, and characters leave in arrival order. A pulse on `rbr_rd_i` removes the head entry, and a pulse on an empty FIFO has no effect.
- R3: Status bits 4 (break), 3 (framing) and 2 (parity) show the flags of the head entry. A status read with no pop in the same cycle clears them, one cycle later, until a pop brings a new head. When a pop and a status read fall in the same cycle, the pop wins and the new head's flags are shown.
- R4: A push with `rx_brk_i` high stores exactly one entry. That entry has data 0x00 with both the break and framing flags set and the parity flag clear, whatever `rx_data_i` carries.
- R5: A push that finds the FIFO full is discarded and sets status bit 1 (overrun). A pop in the same cycle frees a slot, so the push is accepted. Bit 1 stays set until a status read in a cycle with no new overrun.
- R6: The capacity is DEPTH (16) entries when `fifo_en_i` is 1, and one entry when it is 0.
- R7: With the FIFO enabled, status bit 7 is 1 one cycle after any error-tagged entry is present. It stays 1 until a status read made while no error-tagged entry remains after that cycle.
- R8: Status bit 7 reads 0 whenever `fifo_en_i` is 0.
- R9: Status bit 6 is, one cycle later, the AND of `tx_thr_empty_i`, `tx_tsr_empty_i` and `tx_idle_i`, gated by no break being sent.
- R10: Status bit 5 is, one cycle later, `tx_thr_empty_i` gated by no break being sent.
- R11: In the cycle after `tx_brk_i` is high, status bits 6 and 5 are both 0. They can return to 1 only after the break is removed.
- R12: Right after reset the FIFO is empty and the status word reads 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_en_i | input | 1 | 1 = FIFO mode (DEPTH entries), 0 = single holding entry |
| rx_valid_i | input | 1 | Receiver delivers a character this cycle |
| rx_data_i | input | 8 | Received data byte |
| rx_pe_i | input | 1 | Parity check failed |
| rx_fe_i | input | 1 | Stop bit sampled low |
| rx_brk_i | input | 1 | Character slot is a detected break |
| rbr_rd_i | input | 1 | Host reads the receive buffer (pop) |
| lsr_rd_i | input | 1 | Host reads the status word |
| tx_thr_empty_i | input | 1 | Transmit holding FIFO empty |
| tx_tsr_empty_i | input | 1 | Transmit shift register empty |
| tx_idle_i | input | 1 | Transmitter idle |
| tx_brk_i | input | 1 | Break being transmitted |
| rbr_data_o | output | 8 | Head entry data |
| lsr_o | output | 8 | Status word {err, temt, thre, bi, fe, pe, ovr, dr} |

## Verification
Two collisions matter most. The first is a pop and a status read in the same cycle: the acknowledge of the old head must not hide the new head's flags. The second is a push into a full FIFO while the same cycle pops, which must be accepted and raise no overrun. The bench provokes both on purpose with tagged characters and a filled FIFO, then again through a long random phase that drives all strobes at once. A queue-based model predicts every status bit and the head byte, and the bench compares them on every clock.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              bi;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rx_ent_t;

  localparam int ENT_W = $bits(rx_ent_t);
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import lsr_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  rx_ent_t       wdata_i,
  output rx_ent_t       rdata_o,
  output logic [CW-1:0] count_o
);
  rx_ent_t       mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + AW'(1);
      if (pop_i)  rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = (cnt_q != '0) ? mem_q[rd_q] : '0;
  assign count_o = cnt_q;
endmodule

// File: rtl/rx_err_track.sv
module rx_err_track #(
  parameter int CW = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic err_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q;

  assign cnt_d = cnt_q + CW'(inc_i) - CW'(dec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      // sticky: read clears only once no tagged entry remains
      err_q <= (cnt_d != '0) | (err_q & ~clr_i);
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/tx_empty_flags.sv
module tx_empty_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_empty_i,
  input  logic tsr_empty_i,
  input  logic idle_i,
  input  logic brk_i,
  output logic temt_o,
  output logic thre_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temt_o <= 1'b1;
      thre_o <= 1'b1;
    end else begin
      temt_o <= thr_empty_i & tsr_empty_i & idle_i & ~brk_i;
      thre_o <= thr_empty_i & ~brk_i;
    end
  end
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import lsr_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pe_i,
  input  logic              rx_fe_i,
  input  logic              rx_brk_i,
  input  logic              rbr_rd_i,
  input  logic              lsr_rd_i,
  input  logic              tx_thr_empty_i,
  input  logic              tx_tsr_empty_i,
  input  logic              tx_idle_i,
  input  logic              tx_brk_i,
  output logic [DATA_W-1:0] rbr_data_o,
  output logic [7:0]        lsr_o
);
  rx_ent_t       wr_ent, head;
  logic [CW-1:0] fcnt;
  logic          nonempty, full, pop, push;
  logic          ack_q, ovr_q, err, temt, thre;

  assign nonempty = (fcnt != '0);
  assign full     = fifo_en_i ? (fcnt == CW'(DEPTH)) : nonempty;
  assign pop      = rbr_rd_i & nonempty;
  assign push     = rx_valid_i & (~full | pop);

  always_comb begin
    if (rx_brk_i) begin
      wr_ent      = '0;
      wr_ent.bi   = 1'b1;
      wr_ent.fe   = 1'b1;
    end else begin
      wr_ent.bi   = 1'b0;
      wr_ent.fe   = rx_fe_i;
      wr_ent.pe   = rx_pe_i;
      wr_ent.data = rx_data_i;
    end
  end

  rx_tag_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (wr_ent),
    .rdata_o (head),
    .count_o (fcnt)
  );

  rx_err_track #(.CW(CW)) i_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (push & (wr_ent.bi | wr_ent.fe | wr_ent.pe)),
    .dec_i  (pop & (head.bi | head.fe | head.pe)),
    .clr_i  (lsr_rd_i),
    .err_o  (err)
  );

  tx_empty_flags i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .thr_empty_i (tx_thr_empty_i),
    .tsr_empty_i (tx_tsr_empty_i),
    .idle_i      (tx_idle_i),
    .brk_i       (tx_brk_i),
    .temt_o      (temt),
    .thre_o      (thre)
  );

  // head acknowledge: a status read hides the current head's tags; a pop re-arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (pop)                       ack_q <= 1'b0;
      else if (lsr_rd_i && nonempty) ack_q <= 1'b1;
      ovr_q <= (rx_valid_i & ~push) | (ovr_q & ~lsr_rd_i);
    end
  end

  logic show;
  assign show       = nonempty & ~ack_q;
  assign rbr_data_o = head.data;
  assign lsr_o      = {fifo_en_i & err, temt, thre,
                       show & head.bi, show & head.fe, show & head.pe,
                       ovr_q, nonempty};
endmodule

module rx_line_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_en_i,
  input logic       rbr_rd_i,
  input logic       lsr_rd_i,
  input logic       tx_brk_i,
  input logic [7:0] rbr_data_o,
  input logic [7:0] lsr_o
);
  // R1
  empty_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsr_o[0] |-> rbr_data_o == 8'h00);
  // R3
  ack_hide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !rbr_rd_i && lsr_o[0]) |=> lsr_o[4:2] == 3'b000);
  // R5
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_o[1] && !lsr_rd_i) |=> lsr_o[1]);
  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_o[7] && !lsr_rd_i) |=> (lsr_o[7] || !fifo_en_i));
  // R8
  err_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> !lsr_o[7]);
  // R11
  brk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_brk_i |=> (!lsr_o[6] && !lsr_o[5]));
endmodule

bind rx_line_status rx_line_status_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .rbr_rd_i   (rbr_rd_i),
  .lsr_rd_i   (lsr_rd_i),
  .tx_brk_i   (tx_brk_i),
  .rbr_data_o (rbr_data_o),
  .lsr_o      (lsr_o)
);

// File: tb/test_rx_line_status.sv
module test_rx_line_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       fifo_en = 1'b1, rx_valid = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic       thr = 1'b1, tsr = 1'b1, idl = 1'b1, tbrk = 1'b0;
  logic [7:0] rbr_data, lsr;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_line_status #(.DEPTH(DEPTH)) i_rx_line_status (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_pe_i(rx_pe), .rx_fe_i(rx_fe), .rx_brk_i(rx_brk),
    .rbr_rd_i(rbr_rd), .lsr_rd_i(lsr_rd), .tx_thr_empty_i(thr),
    .tx_tsr_empty_i(tsr), .tx_idle_i(idl), .tx_brk_i(tbrk),
    .rbr_data_o(rbr_data), .lsr_o(lsr)
  );

  // behavioural model: entry = {bi, fe, pe, data}
  logic [10:0] mq[$];
  bit m_ack, m_ovr, m_err, m_temt = 1, m_thre = 1;
  bit m_pop, m_acc;
  int m_cap, m_n;

  always @(posedge clk) begin
    if (!rst_ni) begin
      mq.delete(); m_ack = 0; m_ovr = 0; m_err = 0; m_temt = 1; m_thre = 1;
    end else begin
      m_cap = fifo_en ? DEPTH : 1;
      m_pop = rbr_rd && mq.size() > 0;
      m_acc = rx_valid && (mq.size() < m_cap || m_pop);
      if (m_pop) m_ack = 0;
      else if (lsr_rd && mq.size() > 0) m_ack = 1;
      m_ovr = (rx_valid && !m_acc) || (m_ovr && !lsr_rd);
      if (m_pop) void'(mq.pop_front());
      if (m_acc) mq.push_back(rx_brk ? 11'b110_0000_0000 : {1'b0, rx_fe, rx_pe, rx_data});
      m_n = 0;
      foreach (mq[i]) if (mq[i][10:8] != 3'b000) m_n++;
      m_err  = (m_n != 0) || (m_err && !lsr_rd);
      m_temt = thr && tsr && idl && !tbrk;
      m_thre = thr && !tbrk;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  logic [2:0] e_tags;
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      e_tags = (mq.size() > 0 && !m_ack) ? mq[0][10:8] : 3'b000;
      chk("R1", {7'b0, lsr[0]}, {7'b0, mq.size() > 0});
      chk("R2", rbr_data, mq.size() > 0 ? mq[0][7:0] : 8'h00);
      chk("R3", {5'b0, lsr[4:2]}, {5'b0, e_tags});
      chk("R5", {7'b0, lsr[1]}, {7'b0, m_ovr});
      chk(fifo_en ? "R7" : "R8", {7'b0, lsr[7]}, {7'b0, fifo_en && m_err});
      chk(tbrk ? "R11" : "R9", {7'b0, lsr[6]}, {7'b0, m_temt});
      chk(tbrk ? "R11" : "R10", {7'b0, lsr[5]}, {7'b0, m_thre});
    end
  end

  task automatic cyc(input bit v, input logic [7:0] d, input bit pe, input bit fe,
                     input bit brk, input bit rd, input bit lr);
    @(posedge clk); #1;
    rx_valid = v; rx_data = d; rx_pe = pe; rx_fe = fe; rx_brk = brk;
    rbr_rd = rd; lsr_rd = lr;
  endtask

  task automatic settle();
    cyc(0, 8'h00, 0, 0, 0, 0, 0);
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 8'h00, 0, 0, 0, 1, 1);
    settle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk("R12", lsr, 8'h60);

    // R2: in-order storage and pop
    cyc(1, 8'h11, 0, 0, 0, 0, 0);
    cyc(1, 8'h22, 0, 0, 0, 0, 0);
    settle();
    chk("R2", rbr_data, 8'h11);
    cyc(0, 8'h00, 0, 0, 0, 1, 0);
    settle();
    chk("R2", rbr_data, 8'h22);
    drain();
    cyc(0, 8'h00, 0, 0, 0, 1, 0); // pop on empty
    settle();
    chk("R2", lsr, 8'h60);

    // R4: break loads one null entry with BI+FE
    cyc(1, 8'hAA, 1, 0, 1, 0, 0);
    settle();
    chk("R4", rbr_data, 8'h00);
    chk("R4", {3'b0, lsr[4:0]}, 8'b0001_1001);
    chk("R7", {7'b0, lsr[7]}, 8'h01);

    // R3: parity char behind break; pop + status read in same cycle
    cyc(1, 8'h5A, 1, 0, 0, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 1, 1);
    settle();
    chk("R3", {3'b0, lsr[4:0]}, 8'b0000_0101);
    cyc(0, 8'h00, 0, 0, 0, 0, 1);
    settle();
    chk("R3", {3'b0, lsr[4:0]}, 8'b0000_0001);
    cyc(0, 8'h00, 0, 0, 0, 1, 0);
    settle();
    chk("R7", {7'b0, lsr[7]}, 8'h01); // sticky until read
    cyc(0, 8'h00, 0, 0, 0, 0, 1);
    settle();
    chk("R7", {7'b0, lsr[7]}, 8'h00);

    // R6 / R5: fill, overrun, then push+pop on full
    for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i + 1), 0, 0, 0, 0, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0, 0);
    settle();
    chk("R6", {7'b0, lsr[1]}, 8'h01);
    cyc(1, 8'hF0, 0, 1, 0, 1, 0);
    settle();
    chk("R5", {7'b0, lsr[1]}, 8'h01);
    cyc(0, 8'h00, 0, 0, 0, 0, 1);
    settle();
    chk("R5", {7'b0, lsr[1]}, 8'h00);
    drain();

    // R8 / R6: FIFO disabled
    fifo_en = 1'b0;
    cyc(1, 8'h33, 1, 0, 0, 0, 0);
    cyc(1, 8'h44, 0, 0, 0, 0, 0);
    settle();
    chk("R6", {6'b0, lsr[1:0]}, 8'h03);
    chk("R8", {7'b0, lsr[7]}, 8'h00);
    drain();
    fifo_en = 1'b1;

    // R11: break transmission holds tx flags low
    @(posedge clk); #1 tbrk = 1'b1;
    settle();
    chk("R11", {6'b0, lsr[6:5]}, 8'h00);
    @(posedge clk); #1 tbrk = 1'b0;
    settle();
    chk("R9", {6'b0, lsr[6:5]}, 8'h03);
    @(posedge clk); #1 tsr = 1'b0;
    settle();
    chk("R10", {6'b0, lsr[6:5]}, 8'h01);
    tsr = 1'b1;

    // random mix, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 2) != 0, 8'($urandom), $urandom_range(0, 5) == 0,
          $urandom_range(0, 5) == 0, $urandom_range(0, 15) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
      thr = $urandom_range(0, 3) != 0; tsr = $urandom_range(0, 3) != 0;
      idl = $urandom_range(0, 3) != 0; tbrk = $urandom_range(0, 7) == 0;
      if ($urandom_range(0, 199) == 0) fifo_en = ~fifo_en;
    end
    settle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule